// File: doc/BRIEF.md
# Recirculating Multi-Channel Pattern Generator

This block produces six repeating digital waveforms, such as sync or strobe signals for sensors and converters. Each channel holds its own circular bit store. After reset the block is in load mode. A host streams one column of bits per step, one bit for each channel, and every channel takes its bit in the same step. Each column passes through a valid/ready handshake. `load_ready` is high only in a load-mode cycle that carries a step tick. A column is taken only in a cycle where both `load_valid` and `load_ready` are high. A tick that finds `load_valid` low is lost, and nothing shifts. The host holds its column and valid until a ready cycle arrives. This is the back-pressure rule.

Once a full register length of columns has been taken, the block switches to run mode for good. In run mode each channel feeds its last stage back into its first, so the loaded pattern repeats without end. The step tick comes from an internal programmable divider or from an external clock-enable pin, chosen by a select input. The default divider width covers step periods of tens of microseconds at typical system clocks. Any channel can be marked slow: it then advances on every fourth step tick, in phase with the fast channels. Each output is the first stage of its channel.

Top module: `pattern_loop_gen`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears every channel register, drives `pat_out` to 0 and `running` to 0, and returns the block to load mode.
- R2: With `tick_sel`=1 a step tick is any cycle with `ext_tick`=1. With `tick_sel`=0 the internal divider gives a tick every `period_m1`+1 clock cycles.
- R3: `load_ready` is 1 only in load mode, and only in a cycle that carries a step tick. A tick with `load_valid`=0 shifts nothing and does not count toward the load length.
- R4: When a column is accepted, the first stage of channel i takes `load_data[i]`, whatever the feedback bit is. The value shows on `pat_out[i]` in the next cycle.
- R5: `running` rises in the cycle after exactly LEN columns have been accepted and stays at 1 until reset. In run mode `load_data` and `load_valid` have no effect.
- R6: In run mode a fast channel (`slow_mask[i]`=0) shifts on every step tick, with its last stage feeding its first. Its output sequence restarts with the first bit loaded and repeats every LEN ticks.
- R7: A slow channel (`slow_mask[i]`=1) shifts only on the 4th, 8th, 12th, ... run-mode tick, counted from entry into run mode. Its output repeats every 4·LEN ticks and changes only in cycles where the fast channels also step.
- R8: `pat_out` changes only in the cycle after a step tick. Without a tick it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sel | input | 1 | 1: external step tick, 0: internal divider |
| ext_tick | input | 1 | External clock-enable step tick |
| period_m1 | input | DIV_W | Internal step period minus one, in clock cycles |
| slow_mask | input | NUM_CH | Per-channel quarter-rate select |
| load_valid | input | 1 | Host column valid |
| load_ready | output | 1 | Column accepted this cycle if valid |
| load_data | input | NUM_CH | Host column, one bit per channel |
| pat_out | output | NUM_CH | First-stage bit of each channel |
| running | output | 1 | Load finished, patterns recirculating |

## Verification
The bench builds the block with LEN=8, six channels and an 8-bit divider. The short length lets a slow channel complete more than two full periods of 4·LEN=32 ticks in a run of about 80 steps. This puts both periodicity rules and the slow-step phase alignment within reach. The small divider width lets the internal tick interval be measured directly. Most stimulus uses external ticks, so the scoreboard knows exactly which cycle each step lands in. This covers a lost tick during loading, the exact switch to run mode, and the period of each channel class.

// File: rtl/patgen_pkg.sv
package patgen_pkg;
  typedef enum logic {
    MODE_LOAD = 1'b0,
    MODE_RUN  = 1'b1
  } mode_e;

  // ratio between fast and slow channel step rates
  localparam int SLOW_DIV = 4;
endpackage

// File: rtl/patgen_tick.sv
module patgen_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_sel,
  input  logic             ext_tick,
  input  logic [DIV_W-1:0] period_m1,
  output logic             base_tick
);
  logic [DIV_W-1:0] div_cnt;
  logic             div_wrap;

  // >= so that lowering the period mid-count still wraps promptly
  assign div_wrap = (div_cnt >= period_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_cnt <= '0;
    else if (div_wrap) div_cnt <= '0;
    else               div_cnt <= div_cnt + 1'b1;
  end

  assign base_tick = tick_sel ? ext_tick : div_wrap;
endmodule

// File: rtl/patgen_ctrl.sv
module patgen_ctrl
  import patgen_pkg::*;
#(
  parameter int LEN    = 32,
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              load_valid,
  input  logic [NUM_CH-1:0] slow_mask,
  output logic              load_ready,
  output logic              running,
  output logic              load_sel,
  output logic [NUM_CH-1:0] step_en
);
  localparam int CW = $clog2(LEN + 1);
  localparam int PW = $clog2(SLOW_DIV);

  mode_e         mode;
  logic [CW-1:0] beat_cnt;
  logic [PW-1:0] phase;
  logic          accept;
  logic          fast_step;
  logic          slow_step;

  assign load_ready = (mode == MODE_LOAD) && base_tick;
  assign accept     = load_ready && load_valid;
  assign fast_step  = (mode == MODE_RUN) && base_tick;
  assign slow_step  = fast_step && (phase == PW'(SLOW_DIV - 1));
  assign running    = (mode == MODE_RUN);
  assign load_sel   = (mode == MODE_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_LOAD;
      beat_cnt <= '0;
      phase    <= '0;
    end else begin
      if (accept) begin
        if (beat_cnt == CW'(LEN - 1)) begin
          mode     <= MODE_RUN;
          beat_cnt <= '0;
          phase    <= '0;
        end else begin
          beat_cnt <= beat_cnt + 1'b1;
        end
      end
      if (fast_step) phase <= phase + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_step
    assign step_en[i] = accept | (slow_mask[i] ? slow_step : fast_step);
  end
endmodule

// File: rtl/patgen_chan.sv
module patgen_chan #(
  parameter int LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic load_sel,
  input  logic load_bit,
  output logic tap
);
  logic [LEN-1:0] ring;
  logic           din;

  // host bit wins over the feedback path while loading
  assign din = load_sel ? load_bit : ring[LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ring <= '0;
    else if (step) ring <= {ring[LEN-2:0], din};
  end

  assign tap = ring[0];
endmodule

// File: rtl/pattern_loop_gen.sv
module pattern_loop_gen #(
  parameter int NUM_CH = 6,
  parameter int LEN    = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_sel,
  input  logic              ext_tick,
  input  logic [DIV_W-1:0]  period_m1,
  input  logic [NUM_CH-1:0] slow_mask,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [NUM_CH-1:0] load_data,
  output logic [NUM_CH-1:0] pat_out,
  output logic              running
);
  logic              base_tick;
  logic              load_sel;
  logic [NUM_CH-1:0] step_en;

  patgen_tick #(.DIV_W(DIV_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_sel  (tick_sel),
    .ext_tick  (ext_tick),
    .period_m1 (period_m1),
    .base_tick (base_tick)
  );

  patgen_ctrl #(.LEN(LEN), .NUM_CH(NUM_CH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_tick  (base_tick),
    .load_valid (load_valid),
    .slow_mask  (slow_mask),
    .load_ready (load_ready),
    .running    (running),
    .load_sel   (load_sel),
    .step_en    (step_en)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    patgen_chan #(.LEN(LEN)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step_en[i]),
      .load_sel (load_sel),
      .load_bit (load_data[i]),
      .tap      (pat_out[i])
    );
  end
endmodule

// File: rtl/pattern_loop_gen_chk.sv
module pattern_loop_gen_chk #(
  parameter int NUM_CH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_sel,
  input logic              ext_tick,
  input logic              load_valid,
  input logic              load_ready,
  input logic [NUM_CH-1:0] load_data,
  input logic [NUM_CH-1:0] pat_out,
  input logic              running
);
  a_r3_ready_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ready && tick_sel) |-> ext_tick);

  a_r3_ready_only_loading: assert property (@(posedge clk) disable iff (!rst_n)
    load_ready |-> !running);

  a_r4_load_overrides: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ready && load_valid) |=> (pat_out == $past(load_data)));

  a_r5_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  a_r5_run_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(load_ready && load_valid));

  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sel && !ext_tick) |=> $stable(pat_out));
endmodule

bind pattern_loop_gen pattern_loop_gen_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_sel   (tick_sel),
  .ext_tick   (ext_tick),
  .load_valid (load_valid),
  .load_ready (load_ready),
  .load_data  (load_data),
  .pat_out    (pat_out),
  .running    (running)
);

// File: tb/pattern_loop_gen_tb.sv
module pattern_loop_gen_tb;
  localparam int NUM_CH = 6;
  localparam int LEN    = 8;
  localparam int DIV_W  = 8;
  localparam int NRUN   = 80;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_sel = 1'b1;
  logic              ext_tick = 1'b0;
  logic [DIV_W-1:0]  period_m1 = 8'd4;
  logic [NUM_CH-1:0] slow_mask = 6'b100100;
  logic              load_valid = 1'b0;
  logic              load_ready;
  logic [NUM_CH-1:0] load_data = '0;
  logic [NUM_CH-1:0] pat_out;
  logic              running;

  always #2 clk = ~clk;  // 250 MHz

  pattern_loop_gen #(.NUM_CH(NUM_CH), .LEN(LEN), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_sel(tick_sel), .ext_tick(ext_tick),
    .period_m1(period_m1), .slow_mask(slow_mask), .load_valid(load_valid),
    .load_ready(load_ready), .load_data(load_data), .pat_out(pat_out),
    .running(running)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-channel pattern, bit k is loaded in beat k
  logic [LEN-1:0] pat [NUM_CH];
  initial begin
    pat[0] = 8'hB4; pat[1] = 8'h01; pat[2] = 8'hC6;
    pat[3] = 8'h7E; pat[4] = 8'h35; pat[5] = 8'h80;
  end

  function automatic logic [NUM_CH-1:0] column(input int k);
    logic [NUM_CH-1:0] c;
    for (int ch = 0; ch < NUM_CH; ch++) c[ch] = pat[ch][k];
    return c;
  endfunction

  // expected outputs after j run-mode ticks
  function automatic logic [NUM_CH-1:0] run_exp(input int j);
    logic [NUM_CH-1:0] e;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      int s;
      s = slow_mask[ch] ? (j / 4) : j;
      e[ch] = pat[ch][(s + LEN - 1) % LEN];
    end
    return e;
  endfunction

  // scoreboard
  typedef struct {
    logic [NUM_CH-1:0] val;
    string             tag;
  } sb_item_t;
  sb_item_t exp_q[$];
  logic drv_tick = 1'b0;
  logic sb_fire;

  always @(posedge clk) begin
    sb_fire = drv_tick;
    #1;
    if (sb_fire) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else begin
        sb_item_t it;
        it = exp_q.pop_front();
        chk(it.tag, 32'(pat_out), 32'(it.val));
      end
    end
  end

  task automatic drive_tick(input logic vld, input logic [NUM_CH-1:0] data,
                            input logic [NUM_CH-1:0] expv, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.val = expv; it.tag = tag;
    exp_q.push_back(it);
    ext_tick = 1'b1; load_valid = vld; load_data = data; drv_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0; load_valid = 1'b0; drv_tick = 1'b0;
  endtask

  logic [NUM_CH-1:0] hist [NRUN + 1];

  task automatic run_all();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset pat_out", 32'(pat_out), 32'd0);
    chk("R1 reset running", 32'(running), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 no ready without tick", 32'(load_ready), 32'd0);

    // R3: a tick without valid is ready but shifts nothing
    ext_tick = 1'b1;
    #1 chk("R3 ready on load tick", 32'(load_ready), 32'd1);
    @(negedge clk);
    ext_tick = 1'b0;
    chk("R3 idle tick no shift", 32'(pat_out), 32'd0);

    // R4: load columns, each visible next cycle
    for (int k = 0; k < LEN; k++) begin
      if (k == LEN - 1) chk("R5 not running before last beat", 32'(running), 32'd0);
      drive_tick(1'b1, column(k), column(k), "R4 load column");
    end
    chk("R5 running after LEN beats", 32'(running), 32'd1);

    // R6/R7: run with garbage on the load port (R5 ignored)
    hist[0] = pat_out;
    for (int j = 1; j <= NRUN; j++) begin
      drive_tick(1'b1, NUM_CH'($urandom), run_exp(j), "R6/R7 run step");
      hist[j] = pat_out;
    end
    chk("R5 still running", 32'(running), 32'd1);
    for (int j = 4 * LEN + 1; j <= NRUN; j += 7) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (slow_mask[ch]) chk("R7 slow period 4*LEN", 32'(hist[j][ch]), 32'(hist[j - 4 * LEN][ch]));
        else               chk("R6 fast period LEN", 32'(hist[j][ch]), 32'(hist[j - LEN][ch]));
      end
    end

    // R8: no tick, output holds
    repeat (5) @(negedge clk);
    chk("R8 hold without tick", 32'(pat_out), 32'(hist[NRUN]));

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset pat_out", 32'(pat_out), 32'd0);
    chk("R1 mid-run reset running", 32'(running), 32'd0);

    // R2: internal divider, period_m1=4 -> 5 cycles between ticks
    tick_sel = 1'b0; period_m1 = 8'd4; load_valid = 1'b1; load_data = 6'h2A;
    @(negedge clk);
    rst_n = 1'b1;
    for (int rep = 0; rep < 2; rep++) begin
      int gap;
      while (!load_ready) @(negedge clk);
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (!load_ready);
      chk("R2 internal tick interval", 32'(gap), 32'd5);
    end
    repeat (5 * LEN) @(negedge clk);
    chk("R2 internal ticks finish load", 32'(running), 32'd1);
    load_valid = 1'b0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule